// File: doc/BRIEF.md
# Branch Condition Flag Evaluator

This unit decides whether a conditional jump, call or return is taken and works out the program counter that follows it. It has two test forms. The relative form picks one of eight status flags with a 3-bit selector and compares it with a wanted state. Four of the flags come from the ALU and four from the serial transceiver. When the flag matches, the target is the incoming program counter plus a sign-extended 8-bit displacement. The absolute form picks one bit of an 8-bit source register by position and compares it with the wanted state. When the bit matches, a full 16-bit target is loaded.

The sequencer pulses a request strobe with all operands stable. One clock later the unit presents a registered result: a valid pulse, the taken decision and the next program counter. The incoming program counter must already point at the instruction after the branch. Condition mnemonics such as "not zero" or "positive" are only selector and state pairs, so the unit needs no separate condition decoder.

Top module: `branch_cond_eval`

## Requirements
- R1: After reset, and until the first request, `res_valid` and `res_taken` are 0 and `res_pc` is 0.
- R2: In relative mode (`req_abs`=0), `flag_sel` picks the tested flag by this code: 0=alu_zero, 1=alu_carry, 2=alu_ovf, 3=alu_neg, 4=xcv_rx_active, 5=xcv_rx_error, 6=xcv_data_avail, 7=xcv_tx_full.
- R3: In relative mode the branch is taken exactly when the selected flag equals `want_state`. For example, "not zero" is code 0 with state 0, and "positive" is code 3 with state 0.
- R4: A taken relative branch gives `res_pc` = `cur_pc` + sign-extended `rel_ofs`, so the reach is -128 to +127.
- R5: A branch that is not taken, in either mode, gives `res_pc` = `cur_pc`.
- R6: In absolute mode (`req_abs`=1), the branch is taken exactly when bit `bit_pos` (0 = LSB) of `src_reg` equals `want_state`. `flag_sel`, `rel_ofs` and all eight flags have no effect.
- R7: A taken absolute branch gives `res_pc` = `abs_target`.
- R8: The result of a request sampled at a rising edge appears at the outputs after that edge. `res_valid` is 1 for exactly the cycles that follow a cycle with `req_valid`=1.
- R9: In a cycle that follows no request, `res_valid` and `res_taken` are 0 and `res_pc` keeps its last value.
- R10: The relative addition wraps modulo 2^16 at both ends of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, operands valid |
| req_abs | input | 1 | 0 = relative flag test, 1 = absolute bit test |
| alu_zero | input | 1 | ALU zero flag |
| alu_carry | input | 1 | ALU carry flag |
| alu_ovf | input | 1 | ALU overflow flag |
| alu_neg | input | 1 | ALU negative flag |
| xcv_rx_active | input | 1 | Transceiver receiver active |
| xcv_rx_error | input | 1 | Transceiver receiver error |
| xcv_data_avail | input | 1 | Transceiver data available |
| xcv_tx_full | input | 1 | Transceiver transmit FIFO full |
| flag_sel | input | 3 | Flag selector code |
| want_state | input | 1 | State the tested flag or bit must have |
| rel_ofs | input | 8 | Signed relative displacement |
| cur_pc | input | 16 | Address of the instruction after the branch |
| src_reg | input | 8 | Register tested in absolute mode |
| bit_pos | input | 3 | Bit position tested in absolute mode |
| abs_target | input | 16 | Absolute target address |
| res_valid | output | 1 | Result valid pulse |
| res_taken | output | 1 | Branch taken |
| res_pc | output | 16 | Next program counter |

## Verification
The bench builds the unit with its default parameters: a 16-bit program counter, an 8-bit displacement, an 8-bit tested register and eight flags. With these widths every selector code, every bit position and both displacement extremes can be reached directly. The wrap at 0x0000 and 0xFFFF comes within reach of a few directed cases. Random requests then cover the two modes and all flag patterns, including back-to-back strobes and idle gaps.

// File: rtl/branch_cond_eval_pkg.sv
package branch_cond_eval_pkg;

    // Selector codes; the order is fixed by the instruction encoding.
    typedef enum logic [2:0] {
        FLG_ZERO     = 3'd0,
        FLG_CARRY    = 3'd1,
        FLG_OVF      = 3'd2,
        FLG_NEG      = 3'd3,
        FLG_RX_ACT   = 3'd4,
        FLG_RX_ERR   = 3'd5,
        FLG_DATA_AV  = 3'd6,
        FLG_TX_FULL  = 3'd7
    } flag_code_e;

    localparam int unsigned NUM_FLAGS = 8;
    localparam int unsigned SEL_W     = $clog2(NUM_FLAGS);

    typedef enum logic {
        MODE_REL = 1'b0,
        MODE_ABS = 1'b1
    } test_mode_e;

endpackage

// File: rtl/bce_flag_mux.sv
module bce_flag_mux #(
    parameter int unsigned N_FLAGS = 8,
    localparam int unsigned SW     = $clog2(N_FLAGS)
) (
    input  logic [N_FLAGS-1:0] flags,
    input  logic [SW-1:0]      sel,
    output logic               sel_flag
);
    // One-hot decode of the selector, then an AND-OR tree.
    logic [N_FLAGS-1:0] hit;

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_dec
        assign hit[g] = (sel == SW'(g)) & flags[g];
    end

    assign sel_flag = |hit;

    // R2: with all flags high the mux must return 1, with all low it must return 0
    always_comb begin
        if (&flags) begin
            a_r2_all_ones : assert (sel_flag === 1'b1 || $isunknown(sel));
        end
        if (~|flags) begin
            a_r2_all_zero : assert (sel_flag === 1'b0);
        end
    end
endmodule

// File: rtl/bce_bit_pick.sv
module bce_bit_pick #(
    parameter int unsigned REG_W = 8,
    localparam int unsigned PW   = $clog2(REG_W)
) (
    input  logic [REG_W-1:0] reg_val,
    input  logic [PW-1:0]    pos,
    output logic             bit_val
);
    logic [REG_W-1:0] hit;

    for (genvar g = 0; g < REG_W; g++) begin : g_pos
        assign hit[g] = (pos == PW'(g)) & reg_val[g];
    end

    assign bit_val = |hit;

    // R6: a register of all ones yields a one at every position
    always_comb begin
        if (&reg_val) begin
            a_r6_bit_all_ones : assert (bit_val === 1'b1 || $isunknown(pos));
        end
    end
endmodule

// File: rtl/bce_target_calc.sv
module bce_target_calc #(
    parameter int unsigned PC_W  = 16,
    parameter int unsigned OFS_W = 8,
    localparam int unsigned EXT_W = PC_W - OFS_W
) (
    input  logic             is_abs,
    input  logic             take,
    input  logic [PC_W-1:0]  pc_in,
    input  logic [OFS_W-1:0] ofs,
    input  logic [PC_W-1:0]  abs_tgt,
    output logic [PC_W-1:0]  pc_out
);
    logic [PC_W-1:0] ofs_ext;
    logic [PC_W-1:0] rel_tgt;

    // Sign extension; modulo-2^PC_W add (R4, R10)
    assign ofs_ext = {{EXT_W{ofs[OFS_W-1]}}, ofs};
    assign rel_tgt = pc_in + ofs_ext;

    always_comb begin
        if (!take) begin
            pc_out = pc_in;
        end else if (is_abs) begin
            pc_out = abs_tgt;
        end else begin
            pc_out = rel_tgt;
        end
    end
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
    import branch_cond_eval_pkg::*;
#(
    parameter int unsigned PC_W  = 16,
    parameter int unsigned OFS_W = 8,
    parameter int unsigned REG_W = 8,
    localparam int unsigned POS_W = $clog2(REG_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_abs,
    input  logic             alu_zero,
    input  logic             alu_carry,
    input  logic             alu_ovf,
    input  logic             alu_neg,
    input  logic             xcv_rx_active,
    input  logic             xcv_rx_error,
    input  logic             xcv_data_avail,
    input  logic             xcv_tx_full,
    input  logic [2:0]       flag_sel,
    input  logic             want_state,
    input  logic [OFS_W-1:0] rel_ofs,
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [REG_W-1:0] src_reg,
    input  logic [POS_W-1:0] bit_pos,
    input  logic [PC_W-1:0]  abs_target,
    output logic             res_valid,
    output logic             res_taken,
    output logic [PC_W-1:0]  res_pc
);
    typedef struct packed {
        logic            vld;
        logic            taken;
        logic [PC_W-1:0] pc;
    } res_state_t;

    res_state_t st_d, st_q;

    logic [NUM_FLAGS-1:0] flag_vec;
    logic                 flag_bit;
    logic                 reg_bit;
    logic                 tested;
    logic                 take;
    logic [PC_W-1:0]      pc_next;
    test_mode_e           mode;

    // Vector index equals the selector code (R2)
    always_comb begin
        flag_vec               = '0;
        flag_vec[FLG_ZERO]     = alu_zero;
        flag_vec[FLG_CARRY]    = alu_carry;
        flag_vec[FLG_OVF]      = alu_ovf;
        flag_vec[FLG_NEG]      = alu_neg;
        flag_vec[FLG_RX_ACT]   = xcv_rx_active;
        flag_vec[FLG_RX_ERR]   = xcv_rx_error;
        flag_vec[FLG_DATA_AV]  = xcv_data_avail;
        flag_vec[FLG_TX_FULL]  = xcv_tx_full;
    end

    bce_flag_mux #(.N_FLAGS(NUM_FLAGS)) i_flag_mux (
        .flags    (flag_vec),
        .sel      (flag_sel),
        .sel_flag (flag_bit)
    );

    bce_bit_pick #(.REG_W(REG_W)) i_bit_pick (
        .reg_val (src_reg),
        .pos     (bit_pos),
        .bit_val (reg_bit)
    );

    assign mode   = test_mode_e'(req_abs);
    assign tested = (mode == MODE_ABS) ? reg_bit : flag_bit;
    assign take   = (tested == want_state);            // R3, R6

    bce_target_calc #(.PC_W(PC_W), .OFS_W(OFS_W)) i_target (
        .is_abs  (mode == MODE_ABS),
        .take    (take),
        .pc_in   (cur_pc),
        .ofs     (rel_ofs),
        .abs_tgt (abs_target),
        .pc_out  (pc_next)
    );

    always_comb begin
        st_d       = st_q;
        st_d.vld   = req_valid;
        st_d.taken = req_valid & take;
        if (req_valid) begin
            st_d.pc = pc_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.vld;
    assign res_taken = st_q.taken;
    assign res_pc    = st_q.pc;

    // R8: a strobe produces a valid result on the next cycle
    a_r8_valid_follows : assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    // R9: no result without a strobe, and the PC holds
    a_r9_idle_quiet : assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_valid && !res_taken && $stable(res_pc)));

    // R5 / R4: zero displacement lands on the incoming PC whatever the decision
    a_r5_zero_ofs_pc : assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_abs && rel_ofs == '0) |=> res_pc == $past(cur_pc));

    // R7: all-ones register tested for one always jumps to the absolute target
    a_r7_abs_load : assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_abs && (&src_reg) && want_state)
        |=> (res_taken && res_pc == $past(abs_target)));

    // R6: all-zero register tested for one is never taken
    a_r6_abs_zero_reg : assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_abs && src_reg == '0 && want_state)
        |=> (!res_taken && res_pc == $past(cur_pc)));
endmodule

// File: tb/test_branch_cond_eval.sv
module test_branch_cond_eval;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_abs = 1'b0;
    logic [7:0]  flg = '0;
    logic [2:0]  flag_sel = '0;
    logic        want_state = 1'b0;
    logic [7:0]  rel_ofs = '0;
    logic [15:0] cur_pc = '0;
    logic [7:0]  src_reg = '0;
    logic [2:0]  bit_pos = '0;
    logic [15:0] abs_target = '0;
    logic        res_valid;
    logic        res_taken;
    logic [15:0] res_pc;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    branch_cond_eval i_branch_cond_eval (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_abs        (req_abs),
        .alu_zero       (flg[0]),
        .alu_carry      (flg[1]),
        .alu_ovf        (flg[2]),
        .alu_neg        (flg[3]),
        .xcv_rx_active  (flg[4]),
        .xcv_rx_error   (flg[5]),
        .xcv_data_avail (flg[6]),
        .xcv_tx_full    (flg[7]),
        .flag_sel       (flag_sel),
        .want_state     (want_state),
        .rel_ofs        (rel_ofs),
        .cur_pc         (cur_pc),
        .src_reg        (src_reg),
        .bit_pos        (bit_pos),
        .abs_target     (abs_target),
        .res_valid      (res_valid),
        .res_taken      (res_taken),
        .res_pc         (res_pc)
    );

    function automatic logic exp_taken(input logic ab, input logic [7:0] f,
        input logic [2:0] s, input logic w, input logic [7:0] r, input logic [2:0] p);
        return ab ? (r[p] == w) : (f[s] == w);
    endfunction

    function automatic logic [15:0] exp_pc(input logic ab, input logic tk,
        input logic [15:0] pc, input logic [7:0] o, input logic [15:0] t);
        int signed so;
        so = int'($signed(o));
        if (!tk) return pc;
        if (ab) return t;
        return 16'(int'(pc) + so);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one request at a falling edge, check after the next rising edge.
    task automatic issue(input string req, input logic ab, input logic [7:0] f,
        input logic [2:0] s, input logic w, input logic [7:0] o, input logic [15:0] pc,
        input logic [7:0] r, input logic [2:0] p, input logic [15:0] t);
        logic tk;
        tk = exp_taken(ab, f, s, w, r, p);
        req_valid = 1'b1; req_abs = ab; flg = f; flag_sel = s; want_state = w;
        rel_ofs = o; cur_pc = pc; src_reg = r; bit_pos = p; abs_target = t;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid"}, 32'(res_valid), 32'd1);
        check({req, " taken"}, 32'(res_taken), 32'(tk));
        check({req, " pc"}, 32'(res_pc), 32'(exp_pc(ab, tk, pc, o, t)));
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [15:0] held;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", 32'(res_valid), 32'd0);
        check("R1 taken", 32'(res_taken), 32'd0);
        check("R1 pc", 32'(res_pc), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 32'(res_valid), 32'd0);

        // R2 / R3: each selector code, single flag set, both wanted states
        for (int c = 0; c < 8; c++) begin
            issue("R2 one-hot match", 1'b0, 8'(1 << c), 3'(c), 1'b1, 8'h10, 16'h1000, 8'h00, 3'd0, 16'h0);
            issue("R3 one-hot mismatch", 1'b0, 8'(1 << c), 3'(c), 1'b0, 8'h10, 16'h1000, 8'h00, 3'd0, 16'h0);
            issue("R2 inverted flags", 1'b0, ~8'(1 << c), 3'(c), 1'b0, 8'h22, 16'h2000, 8'h00, 3'd0, 16'h0);
        end
        // R3: aliases "not zero" (0,0) and "positive" (3,0)
        issue("R3 not-zero", 1'b0, 8'h00, 3'd0, 1'b0, 8'h05, 16'h0100, 8'h00, 3'd0, 16'h0);
        issue("R3 positive", 1'b0, 8'h08, 3'd3, 1'b0, 8'h05, 16'h0100, 8'h00, 3'd0, 16'h0);
        // R4: displacement extremes
        issue("R4 ofs -128", 1'b0, 8'h01, 3'd0, 1'b1, 8'h80, 16'h4000, 8'h00, 3'd0, 16'h0);
        issue("R4 ofs +127", 1'b0, 8'h01, 3'd0, 1'b1, 8'h7F, 16'h4000, 8'h00, 3'd0, 16'h0);
        // R10: wrap at both ends
        issue("R10 wrap low", 1'b0, 8'h02, 3'd1, 1'b1, 8'hFC, 16'h0002, 8'h00, 3'd0, 16'h0);
        issue("R10 wrap high", 1'b0, 8'h02, 3'd1, 1'b1, 8'h7F, 16'hFFF0, 8'h00, 3'd0, 16'h0);
        // R5: not taken keeps the PC
        issue("R5 not taken rel", 1'b0, 8'hFF, 3'd6, 1'b0, 8'h40, 16'hABCD, 8'h00, 3'd0, 16'h0);
        // R6 / R7: each bit position, flags and selector set against the outcome
        for (int b = 0; b < 8; b++) begin
            issue("R7 abs bit set", 1'b1, 8'h00, 3'd0, 1'b1, 8'h7F, 16'h1234, 8'(1 << b), 3'(b), 16'hBEEF);
            issue("R6 abs bit clear", 1'b1, 8'hFF, 3'd0, 1'b1, 8'h7F, 16'h1234, ~8'(1 << b), 3'(b), 16'hBEEF);
            issue("R6 abs want zero", 1'b1, 8'hFF, 3'd5, 1'b0, 8'h01, 16'h0FF0, ~8'(1 << b), 3'(b), 16'hCAFE);
        end

        // R8 / R9: idle cycles after a request
        issue("R8 pre-idle", 1'b0, 8'h01, 3'd0, 1'b1, 8'h04, 16'h0300, 8'h00, 3'd0, 16'h0);
        held = res_pc;
        flg = 8'h00; cur_pc = 16'h7777; abs_target = 16'h5555; req_abs = 1'b1; src_reg = 8'hFF;
        want_state = 1'b1;
        repeat (2) begin
            @(negedge clk);
            check("R9 idle valid", 32'(res_valid), 32'd0);
            check("R9 idle taken", 32'(res_taken), 32'd0);
            check("R9 idle pc hold", 32'(res_pc), 32'(held));
        end

        // Random mix, back-to-back with occasional gaps (R3..R8)
        for (int i = 0; i < 600; i++) begin
            issue("R3-R7 random", 1'($urandom), 8'($urandom), 3'($urandom), 1'($urandom),
                  8'($urandom), 16'($urandom), 8'($urandom), 3'($urandom), 16'($urandom));
            if ($urandom_range(0, 3) == 0) begin
                held = res_pc;
                @(negedge clk);
                check("R9 random gap valid", 32'(res_valid), 32'd0);
                check("R9 random gap pc", 32'(res_pc), 32'(held));
            end
        end

        done = 1'b1;
        finish_run();
    end
endmodule